// File: doc/BRIEF.md
# SPI Flash Opcode-Menu Cycle Sequencer

This block is a host-side SPI master that runs one flash transaction at a time under software control. Software loads an eight-entry opcode menu, a 24-bit flash address, a prefix opcode and a 64-byte data buffer through a small register port. It then writes the control register with a menu pointer, a byte count, a data-phase enable and the go bit. The block drives chip select, SCLK and MOSI in SPI mode 0 and samples MISO. It serialises the opcode, the address when the menu entry calls for one, and the data bytes.

Each menu entry pairs an opcode with a type. The type sets the direction of the data phase and whether the address is sent. An atomic option first sends the prefix opcode (typically a write enable) in its own chip-select frame. Completion is reported through a sticky done flag that software clears by writing 1 to it. A go written while a transaction is running is dropped and sets a sticky error flag.

Top module: `spi_menu_seq`

## Requirements
- R1: After reset, chip select is high, SCLK is low, and the status register (address 0x03) reads 0.
- R2: Writing the control register (address 0x00) with bit 1 set, while idle, starts one transaction. The first frame byte after any prefix is the opcode of the menu entry chosen by control bits 6:4. Menu entry i sits at address 0x08+i, with the opcode in bits 7:0. All bytes are sent MSB first in SPI mode 0: MOSI changes while SCLK is low, and MISO is sampled on the rising edge.
- R3: Menu bits 9:8 give the entry type: 0 read without address, 1 read with address, 2 write without address, 3 write with address. Types 1 and 3 send the 24-bit address register (address 0x02) MSB first, straight after the opcode. Types 0 and 2 send no address.
- R4: Control bit 14 enables the data phase. Control bits 13:8 hold the byte count minus one (1 to 64 bytes). For write types the frame then carries buffer bytes 0..n-1, where buffer byte k sits at address 0x40+k. With bit 14 clear, the frame ends after the opcode and any address.
- R5: For read types, MOSI carries 0x00 in each data byte. The byte received in data slot k is stored in buffer byte k, and software reads it back at address 0x40+k.
- R6: With control bit 2 set, the prefix opcode register (address 0x01, bits 7:0) is sent alone in a first frame. Chip select then stays high for at least one SCLK period before the main frame begins.
- R7: Chip select falls at least one SCLK half-period before the first rising SCLK edge of every frame. SCLK is low whenever chip select is high.
- R8: Status bit 2 (busy) is high while a transaction runs. Status bit 0 (done) is set when chip select rises at the end of the transaction. Done is cleared by writing 1 to status bit 0. A set and a clear in the same cycle leave done set.
- R9: A go written while busy is ignored: the running frame's bytes and the frame count are unchanged. It sets status bit 1 (error), which is cleared by writing 1 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Two of the block's functions can land in the same cycle: the end of a transaction setting the done flag, and a software write-1-to-clear of that flag. The bench forces the collision by holding a status write of 1 on the register port on every cycle while a transaction finishes. It samples status after every edge. It expects done to read 1 in the sample where busy first drops, and 0 one cycle later. A second overlap, a go arriving mid-frame, is judged by comparing the captured frame bytes against the original menu entry and by checking the error flag.

// File: rtl/spi_seq_pkg.sv
// Shared types and register decode constants for the opcode-menu sequencer.
// Assumes a 7-bit register address space with the data buffer in the upper half.
package spi_seq_pkg;
    typedef enum logic [1:0] {
        KIND_RD_NOADR = 2'd0,
        KIND_RD_ADR   = 2'd1,
        KIND_WR_NOADR = 2'd2,
        KIND_WR_ADR   = 2'd3
    } op_kind_t;

    typedef struct packed {
        op_kind_t   kind;
        logic [7:0] opc;
    } menu_ent_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PRE, ST_GAP, ST_OPC, ST_ADR, ST_DAT
    } seq_state_t;

    localparam logic [6:0] A_CTRL   = 7'h00;
    localparam logic [6:0] A_PREFIX = 7'h01;
    localparam logic [6:0] A_FADDR  = 7'h02;
    localparam logic [6:0] A_STAT   = 7'h03;
    localparam logic [6:0] A_MENU   = 7'h08;

    localparam int B_GO   = 1;
    localparam int B_ATOM = 2;
    localparam int B_PTR  = 4;
    localparam int B_CNT  = 8;
    localparam int B_DEN  = 14;
endpackage

// File: rtl/spi_seq_shift.sv
// Byte serialiser for SPI mode 0. A start pulse loads one byte. MOSI holds the
// current MSB, MISO is sampled on each rising SCLK edge, and the data shifts on
// the falling edge. A one-cycle done pulse follows the eighth falling edge.
// Assumes start is only pulsed while idle; each SCLK half-period is HALF_DIV clocks.
module spi_seq_shift #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic          act;
    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    sh;

    // Half-period timing, edge generation, and shift/sample of one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act <= 1'b0; cnt <= '0; bitn <= '0; sh <= '0;
            sclk <= 1'b0; done <= 1'b0; rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                act <= 1'b1; sh <= tx_byte; sclk <= 1'b0; cnt <= '0; bitn <= '0;
            end else if (act) begin
                if (cnt == LAST) begin
                    cnt <= '0;
                    if (!sclk) begin
                        sclk    <= 1'b1;
                        rx_byte <= {rx_byte[6:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bitn == 3'd7) begin
                            act  <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            bitn <= bitn + 3'd1;
                            sh   <= {sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign mosi = sh[7];

    // R2: the sequencer never restarts the serialiser mid-byte.
    p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !act);
endmodule

// File: rtl/spi_seq_regs.sv
// Software-visible configuration: the opcode menu, the prefix opcode and the
// 24-bit flash address. Provides the menu entry picked by sel and a readback.
// Assumes software does not rewrite these while a transaction is running.
module spi_seq_regs
    import spi_seq_pkg::*;
#(
    parameter int MENU_N = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [6:0]                addr,
    input  logic [31:0]               wdata,
    input  logic [$clog2(MENU_N)-1:0] sel,
    output menu_ent_t                 sel_ent,
    output logic [7:0]                prefix,
    output logic [23:0]               faddr,
    output logic [31:0]               rdata
);
    localparam int PW = $clog2(MENU_N);

    menu_ent_t menu [MENU_N];

    // One register per menu entry, written at its own address.
    for (genvar i = 0; i < MENU_N; i++) begin : g_menu
        always_ff @(posedge clk) begin
            if (!rst_n)
                menu[i] <= '0;
            else if (we && addr == A_MENU + 7'(i))
                menu[i] <= menu_ent_t'(wdata[9:0]);
        end
    end

    // Prefix opcode and flash address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prefix <= '0;
            faddr  <= '0;
        end else if (we) begin
            if (addr == A_PREFIX) prefix <= wdata[7:0];
            if (addr == A_FADDR)  faddr  <= wdata[23:0];
        end
    end

    assign sel_ent = menu[sel];

    // Readback mux over the configuration registers.
    always_comb begin
        rdata = '0;
        if (addr == A_PREFIX)      rdata = {24'b0, prefix};
        else if (addr == A_FADDR)  rdata = {8'b0, faddr};
        else if (addr >= A_MENU && addr < A_MENU + 7'(MENU_N))
            rdata = {22'b0, menu[addr[PW-1:0]]};
    end
endmodule

// File: rtl/spi_seq_buf.sv
// Data buffer with one shared write port and two read ports (software and
// sequencer). A sequencer write takes priority over a software write in the
// same cycle.
module spi_seq_buf #(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     sw_we,
    input  logic [$clog2(DEPTH)-1:0] sw_idx,
    input  logic [7:0]               sw_wd,
    output logic [7:0]               sw_rd,
    input  logic                     eng_we,
    input  logic [$clog2(DEPTH)-1:0] eng_widx,
    input  logic [7:0]               eng_wd,
    input  logic [$clog2(DEPTH)-1:0] eng_ridx,
    output logic [7:0]               eng_rd
);
    logic [7:0] mem [DEPTH];

    // Single write port, sequencer first.
    always_ff @(posedge clk) begin
        if (eng_we)     mem[eng_widx] <= eng_wd;
        else if (sw_we) mem[sw_idx]   <= sw_wd;
    end

    assign sw_rd  = mem[sw_idx];
    assign eng_rd = mem[eng_ridx];
endmodule

// File: rtl/spi_menu_seq.sv
// Opcode-menu SPI flash cycle sequencer (top). Decodes the register port and
// runs the frame sequence: optional prefix frame, gap, opcode, optional 24-bit
// address, then optional data bytes. Reports through sticky done/error flags.
// Assumes BUF_DEPTH matches the 6-bit count field (64 bytes).
module spi_menu_seq
    import spi_seq_pkg::*;
#(
    parameter int HALF_DIV  = 2,
    parameter int MENU_N    = 8,
    parameter int BUF_DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [6:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_cs_n,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int PW = $clog2(MENU_N);
    localparam int CW = $clog2(BUF_DEPTH);
    localparam int GW = $clog2(2 * HALF_DIV) + 1;
    localparam logic [GW-1:0] GAP_LAST = GW'(2 * HALF_DIV - 1);

    seq_state_t    state;
    logic          done_q, err_q, bstart, bdone;
    logic [7:0]    btx, rx_byte, prefix, buf_rd, sw_rbyte;
    logic [23:0]   faddr;
    logic [31:0]   cfg_rdata;
    menu_ent_t     ent;
    logic [PW-1:0] ptr_q;
    logic [CW-1:0] cnt_q, idx, nxt_idx;
    logic [1:0]    adr_i;
    logic [GW-1:0] gcnt;
    logic          den_q, is_wr, has_adr, busy, go_wr, sw_buf_we;
    op_kind_t      kind_q;
    logic [7:0]    opc_q;
    logic [15:0]   hi_cnt;

    assign busy      = (state != ST_IDLE);
    assign go_wr     = reg_we && reg_addr == A_CTRL && reg_wdata[B_GO];
    assign sw_buf_we = reg_we && reg_addr[6];
    assign is_wr     = kind_q[1];
    assign has_adr   = kind_q[0];
    assign nxt_idx   = (state == ST_DAT) ? idx + 1'b1 : '0;

    spi_seq_regs #(.MENU_N(MENU_N)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .sel(busy ? ptr_q : reg_wdata[B_PTR +: PW]), .sel_ent(ent),
        .prefix(prefix), .faddr(faddr), .rdata(cfg_rdata)
    );

    spi_seq_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk(clk), .sw_we(sw_buf_we), .sw_idx(reg_addr[CW-1:0]), .sw_wd(reg_wdata[7:0]),
        .sw_rd(sw_rbyte), .eng_we(bdone && state == ST_DAT && !is_wr),
        .eng_widx(idx), .eng_wd(rx_byte), .eng_ridx(nxt_idx), .eng_rd(buf_rd)
    );

    spi_seq_shift #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(bstart), .tx_byte(btx), .miso(spi_miso),
        .sclk(spi_sclk), .mosi(spi_mosi), .done(bdone), .rx_byte(rx_byte)
    );

    // Frame sequencing, chip select, and sticky status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; spi_cs_n <= 1'b1; bstart <= 1'b0; btx <= '0;
            done_q <= 1'b0; err_q <= 1'b0; ptr_q <= '0; cnt_q <= '0; den_q <= 1'b0;
            kind_q <= KIND_RD_NOADR; opc_q <= '0; idx <= '0; adr_i <= '0; gcnt <= '0;
        end else begin
            bstart <= 1'b0;
            if (reg_we && reg_addr == A_STAT) begin
                done_q <= done_q & ~reg_wdata[0];
                err_q  <= err_q  & ~reg_wdata[1];
            end
            if (go_wr && busy) err_q <= 1'b1;
            case (state)
                ST_IDLE: if (go_wr) begin
                    ptr_q  <= reg_wdata[B_PTR +: PW];
                    cnt_q  <= reg_wdata[B_CNT +: CW];
                    den_q  <= reg_wdata[B_DEN];
                    kind_q <= ent.kind;
                    opc_q  <= ent.opc;
                    spi_cs_n <= 1'b0;
                    bstart <= 1'b1;
                    btx    <= reg_wdata[B_ATOM] ? prefix : ent.opc;
                    state  <= reg_wdata[B_ATOM] ? ST_PRE : ST_OPC;
                end
                ST_PRE: if (bdone) begin
                    spi_cs_n <= 1'b1; gcnt <= '0; state <= ST_GAP;
                end
                ST_GAP: if (gcnt == GAP_LAST) begin
                    spi_cs_n <= 1'b0; bstart <= 1'b1; btx <= opc_q; state <= ST_OPC;
                end else begin
                    gcnt <= gcnt + 1'b1;
                end
                default: if (bdone) begin
                    if (state == ST_OPC && has_adr) begin
                        btx <= faddr[23:16]; adr_i <= '0; bstart <= 1'b1; state <= ST_ADR;
                    end else if (state == ST_ADR && adr_i != 2'd2) begin
                        btx <= (adr_i == 2'd0) ? faddr[15:8] : faddr[7:0];
                        adr_i <= adr_i + 2'd1; bstart <= 1'b1;
                    end else if (state != ST_DAT && den_q) begin
                        idx <= '0; btx <= is_wr ? buf_rd : 8'h00;
                        bstart <= 1'b1; state <= ST_DAT;
                    end else if (state == ST_DAT && idx != cnt_q) begin
                        idx <= nxt_idx; btx <= is_wr ? buf_rd : 8'h00; bstart <= 1'b1;
                    end else begin
                        spi_cs_n <= 1'b1; done_q <= 1'b1; state <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // Length of the current chip-select high stretch, for the gap check.
    always_ff @(posedge clk) begin
        if (!rst_n)                   hi_cnt <= '0;
        else if (!spi_cs_n)           hi_cnt <= '0;
        else if (hi_cnt != 16'hFFFF)  hi_cnt <= hi_cnt + 16'd1;
    end

    // Register read mux: buffer, status, or configuration.
    always_comb begin
        if (reg_addr[6])                reg_rdata = {24'b0, sw_rbyte};
        else if (reg_addr == A_STAT)    reg_rdata = {29'b0, busy, err_q, done_q};
        else                            reg_rdata = cfg_rdata;
    end

    // R7: the serial clock stays low outside a frame.
    p_sclk_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);
    // R7: no rising SCLK edge in the cycle after chip select falls.
    p_cs_setup_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> !spi_sclk);
    // R6: a frame that starts mid-transaction follows a gap of one SCLK period or more.
    p_frame_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(spi_cs_n) && $past(busy)) |-> hi_cnt >= 16'(2 * HALF_DIV));
    // R8: the end of a transaction leaves done set.
    p_done_on_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_q);
    // R8: chip select is high whenever the sequencer is idle.
    p_idle_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);
    // R9: a go written during a transaction flags an error.
    p_go_busy_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (go_wr && busy) |=> err_q);
endmodule

// File: tb/spi_menu_seq_test.sv
module spi_menu_seq_test;
    localparam int H = 2;

    logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, spi_miso = 1'b0;
    logic [6:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic spi_cs_n, spi_sclk, spi_mosi;

    spi_menu_seq #(.HALF_DIV(H)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Flash model: captures frames, answers with a position-based byte pattern.
    int nfr = 0, flen [2], gap2 = 0, setup = 0, hi = 0, lowc = 0, bitc = 0;
    logic [7:0] fr [2][80];
    logic [7:0] shin = '0, salt = 8'h11;
    bit pcs = 1, psck = 0, sdone = 1;

    function automatic logic [7:0] resp(input int pos);
        return 8'(pos * 29 + 90) ^ salt;
    endfunction

    always @(negedge clk) begin
        logic [7:0] rb;
        if (pcs && !spi_cs_n) begin
            if (nfr == 1) gap2 = hi;
            if (nfr < 2) flen[nfr] = 0;
            nfr++; bitc = 0; lowc = 0; sdone = 0;
            rb = resp(0); spi_miso = rb[7];
        end
        if (!spi_cs_n && !sdone) begin
            if (spi_sclk) begin setup = lowc; sdone = 1; end
            else lowc++;
        end
        if (!psck && spi_sclk && !spi_cs_n && nfr >= 1 && nfr <= 2) begin
            shin = {shin[6:0], spi_mosi}; bitc++;
            if (bitc == 8) begin
                if (flen[nfr-1] < 80) fr[nfr-1][flen[nfr-1]] = shin;
                flen[nfr-1]++; bitc = 0;
            end
        end
        if (psck && !spi_sclk && !spi_cs_n && nfr >= 1 && nfr <= 2) begin
            rb = resp(flen[nfr-1]);
            spi_miso = rb[7 - bitc];
        end
        hi = spi_cs_n ? hi + 1 : 0;
        pcs = spi_cs_n; psck = spi_sclk;
    end

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(7'h03, s);
            if (!s[2]) break;
        end
    endtask

    function automatic logic [7:0] opc_of(input int p);
        return 8'(8'h03 + p * 8'h20);
    endfunction

    function automatic logic [7:0] wpat(input int k);
        return 8'(k * 13) ^ salt;
    endfunction

    // One transaction, built from the requirements and checked at the pins.
    task automatic run(input int p, input int kind, input bit atom, input bit den, input int n);
        logic [31:0] s, d;
        int hdr, exp_len, bad;
        bit wr_k, adr_k;
        logic [23:0] fa;
        wr_k = kind[1]; adr_k = kind[0];
        salt = salt + 8'h3B;
        fa = {salt, 8'h5C, ~salt};
        wr(7'(8 + p), {22'b0, 2'(kind), opc_of(p)});
        wr(7'h01, {24'b0, 8'h06 ^ salt});
        wr(7'h02, {8'b0, fa});
        if (wr_k && den) for (int k = 0; k < n; k++) wr(7'(64 + k), {24'b0, wpat(k)});
        nfr = 0;
        wr(7'h00, {17'b0, den, 6'(n - 1), 1'b0, 3'(p), 1'b0, atom, 1'b1, 1'b0});
        wait_idle();
        chk(nfr == (atom ? 2 : 1), "R6 frame count", nfr, atom ? 2 : 1);
        if (atom) begin
            chk(flen[0] == 1 && fr[0][0] == (8'h06 ^ salt), "R6 prefix byte", fr[0][0], 8'h06 ^ salt);
            chk(gap2 >= 2 * H, "R6 gap", gap2, 2 * H);
        end
        chk(fr[nfr-1][0] == opc_of(p), "R2 opcode", fr[nfr-1][0], opc_of(p));
        hdr = adr_k ? 4 : 1;
        exp_len = hdr + (den ? n : 0);
        chk(flen[nfr-1] == exp_len, "R4 frame length", flen[nfr-1], exp_len);
        if (adr_k)
            chk({fr[nfr-1][1], fr[nfr-1][2], fr[nfr-1][3]} == fa, "R3 address",
                {fr[nfr-1][1], fr[nfr-1][2], fr[nfr-1][3]}, fa);
        if (den) begin
            bad = 0;
            for (int k = 0; k < n; k++) begin
                if (wr_k) begin
                    if (fr[nfr-1][hdr+k] != wpat(k)) bad++;
                end else begin
                    rd(7'(64 + k), d);
                    if (fr[nfr-1][hdr+k] != 8'h00 || d[7:0] != resp(hdr + k)) bad++;
                end
            end
            chk(bad == 0, wr_k ? "R4 write data" : "R5 read data", bad, 0);
        end
        chk(setup >= H, "R7 cs setup", setup, H);
        rd(7'h03, s);
        chk(s[2:0] == 3'b001, "R8 done after end", s[2:0], 1);
        wr(7'h03, 32'h1);
        rd(7'h03, s);
        chk(s[0] == 1'b0, "R8 done cleared", s[0], 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] s;
        int nn [8] = '{1, 2, 7, 64, 3, 33, 5, 1};
        bit seen_end, ok1, ok2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        rd(7'h03, s);
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 pins after reset", {spi_cs_n, spi_sclk}, 2'b10);
        chk(s == 32'h0, "R1 status after reset", s, 0);

        // Sweep every pointer, every type, and atomic/data combinations.
        for (int p = 0; p < 8; p++) run(p, p % 4, p[0], p < 6, nn[p]);
        for (int c = 0; c < 16; c++) run(c % 8, c % 4, c[2], c[3], 2);
        run(2, 1, 1'b0, 1'b1, 64);
        run(6, 3, 1'b1, 1'b1, 64);

        // R9: a go during a running read is dropped and flags an error.
        nfr = 0;
        wr(7'h08 + 7'd4, {22'b0, 2'd1, opc_of(4)});
        wr(7'h08 + 7'd5, {22'b0, 2'd3, opc_of(5)});
        wr(7'h00, {17'b0, 1'b1, 6'd7, 1'b0, 3'd4, 1'b0, 1'b0, 1'b1, 1'b0});
        repeat (60) @(negedge clk);
        wr(7'h00, {17'b0, 1'b1, 6'd1, 1'b0, 3'd5, 1'b0, 1'b1, 1'b1, 1'b0});
        wait_idle();
        rd(7'h03, s);
        chk(s[1] == 1'b1, "R9 error set", s[1], 1);
        chk(nfr == 1 && fr[0][0] == opc_of(4) && flen[0] == 12, "R9 frame unchanged", fr[0][0], opc_of(4));
        wr(7'h03, 32'h3);
        rd(7'h03, s);
        chk(s[1:0] == 2'b00, "R9 error cleared", s[1:0], 0);

        // R8: done set and write-1-to-clear in the same cycle; set must win.
        wr(7'h08, {22'b0, 2'd0, 8'h9F});
        wr(7'h00, {17'b0, 1'b0, 6'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0});
        @(negedge clk); reg_we = 1'b1; reg_addr = 7'h03; reg_wdata = 32'h1;
        seen_end = 0; ok1 = 0; ok2 = 0;
        for (int i = 0; i < 2000 && !seen_end; i++) begin
            @(negedge clk); #1;
            if (!reg_rdata[2]) begin
                seen_end = 1; ok1 = reg_rdata[0];
                @(negedge clk); #1; ok2 = !reg_rdata[0];
            end
        end
        reg_we = 1'b0;
        chk(seen_end && ok1, "R8 set beats clear", ok1, 1);
        chk(ok2, "R8 clear next cycle", ok2, 1);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule